// File: doc/BRIEF.md
# Command-Word Register Bridge

The bridge lets a host reach the 8-bit internal registers of a two-wire serial controller through a single 64-bit command word. The host posts one word that carries a start flag, an operation class, a register selector, a direction bit and a data byte. The bridge waits a fixed number of cycles, performs the internal access, and then drops the start flag. For a read, it also replaces the low byte of the word with the value it fetched. Software therefore posts a command and polls the word until bit 63 reads 0.

A second host word holds the interrupt enable and the two bus-override controls, which software uses to free a stuck bus by hand. The serial engine behind the bridge is reduced to a small register model: a data byte, a control byte, a clock-control byte, a clock high-period byte and a status code. Setting the start bit moves the status code away from idle. Setting the stop bit or a soft reset returns it to idle.

The host port is a plain register port with no back-pressure. A write is taken in the cycle it is presented, or it is dropped. Reads are combinational on the offset.

Top module: `twsi_cmd_bridge`

## Requirements
- R1: After reset, the word at offset 0x00 reads 0, the word at offset 0x10 reads 0, `irq` is 0, both force outputs are 0, and an internal status read returns the idle code 0xF8.
- R2: A host write to offset 0x00 whose bit 63 is 1 starts an access. Bit 63 then reads 1 for exactly LATENCY cycles and 0 afterwards. Bits 62:8 keep the posted value.
- R3: When bit 56 is 1 the access is a read, and on completion bits 7:0 hold the selected register's value. When bit 56 is 0 the access writes bits 7:0 into the register, and bits 7:0 of the word are left unchanged.
- R4: With bits 59:58 = 11, selector bits 34:32 pick the register: 1 is data, 2 is control, 3 writes clock-control and reads status. The clock-control byte drives `clk_div_cfg`.
- R5: With bits 59:58 = 10 and selector 0, the access targets the clock high-period byte, which is readable and drives `clk_hi_period`.
- R6: A write with bits 59:58 = 11 and selector 7 is a soft reset. It sets the status to 0xF8 and clears data and control, and it leaves clock-control and the high-period byte unchanged.
- R7: A control write with bit 4 (stop) set makes the status 0xF8. Otherwise, bit 5 (start) set makes it 0x08. If neither bit is set, the status is kept.
- R8: A host write to offset 0x00 while bit 63 is still 1 is ignored.
- R9: At offset 0x10, bit 6 is the interrupt enable, bit 9 drives `scl_force` and bit 8 drives `sda_force`. All other bits read 0. This word accepts writes at any time.
- R10: `irq` is 1 exactly when the interrupt enable is set and the status differs from 0xF8.
- R11: Any other combination of operation class and selector still completes. As a write it changes no register, and as a read it returns 0 in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Host write strobe |
| csr_addr | input | ADDR_W | Host byte offset (0x00 command word, 0x10 control word) |
| csr_wdata | input | 64 | Host write data |
| csr_rdata | output | 64 | Host read data for `csr_addr` |
| irq | output | 1 | Interrupt request |
| scl_force | output | 1 | Clock-line override |
| sda_force | output | 1 | Data-line override |
| clk_div_cfg | output | 8 | Clock-control byte for the serial engine |
| clk_hi_period | output | 8 | Clock high-period byte for the serial engine |

## Verification
The hardest case to reach is a host write that lands inside the busy window. Software that polls correctly never produces it. The bench therefore issues a second command on the very next cycle, without polling. It then shows that neither the word nor the data register took the second command. A control byte with both start and stop set is posted to confirm that stop wins. A soft reset is posted while the status is away from idle, and every register is then read back, including the ones the reset must leave alone.

// File: rtl/twsi_br_pkg.sv
package twsi_br_pkg;
  localparam int WORD_W    = 64;
  localparam int VALID_BIT = 63;
  localparam int RD_BIT    = 56;
  localparam int OP_HI     = 59;
  localparam int OP_LO     = 58;
  localparam int SEL_HI    = 34;
  localparam int SEL_LO    = 32;

  localparam logic [7:0] ST_IDLE  = 8'hF8;
  localparam logic [7:0] ST_START = 8'h08;
  localparam int CTL_START_BIT = 5;
  localparam int CTL_STOP_BIT  = 4;

  localparam int AUX_IRQ_BIT = 6;
  localparam int AUX_SDA_BIT = 8;
  localparam int AUX_SCL_BIT = 9;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_DATA, TGT_CTL, TGT_CLK, TGT_RST, TGT_THP
  } twsi_tgt_e;
endpackage

// File: rtl/twsi_cmd_decode.sv
module twsi_cmd_decode
  import twsi_br_pkg::*;
(
  input  logic [1:0] op,
  input  logic [2:0] sel,
  output twsi_tgt_e  tgt
);
  always_comb begin
    tgt = TGT_NONE;
    if (op == 2'b11) begin
      case (sel)
        3'd1:    tgt = TGT_DATA;
        3'd2:    tgt = TGT_CTL;
        3'd3:    tgt = TGT_CLK;
        3'd7:    tgt = TGT_RST;
        default: tgt = TGT_NONE;
      endcase
    end else if (op == 2'b10 && sel == 3'd0) begin
      tgt = TGT_THP;
    end
  end
endmodule

// File: rtl/twsi_reg_model.sv
module twsi_reg_model
  import twsi_br_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  twsi_tgt_e  tgt,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] status,
  output logic [7:0] clk_cfg,
  output logic [7:0] hi_period
);
  logic [7:0] data_q, ctl_q, clk_q, thp_q, st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= '0;
      clk_q  <= '0;
      thp_q  <= '0;
      st_q   <= ST_IDLE;
    end else if (we) begin
      case (tgt)
        TGT_DATA: data_q <= wdata;
        TGT_CTL: begin
          ctl_q <= wdata;
          if (wdata[CTL_STOP_BIT])       st_q <= ST_IDLE;
          else if (wdata[CTL_START_BIT]) st_q <= ST_START;
        end
        TGT_CLK:  clk_q <= wdata;
        TGT_THP:  thp_q <= wdata;
        TGT_RST: begin
          data_q <= '0;
          ctl_q  <= '0;
          st_q   <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (tgt)
      TGT_DATA: rdata = data_q;
      TGT_CTL:  rdata = ctl_q;
      TGT_CLK:  rdata = st_q;
      TGT_THP:  rdata = thp_q;
      default:  rdata = '0;
    endcase
  end

  assign status    = st_q;
  assign clk_cfg   = clk_q;
  assign hi_period = thp_q;

  a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (we && tgt == TGT_RST) |=> (st_q == ST_IDLE && ctl_q == 8'h00 && data_q == 8'h00));
  a_r7_start_code: assert property (@(posedge clk) disable iff (!rst_n)
    (we && tgt == TGT_CTL && wdata[CTL_START_BIT] && !wdata[CTL_STOP_BIT]) |=> st_q == ST_START);
  a_r7_stop_code: assert property (@(posedge clk) disable iff (!rst_n)
    (we && tgt == TGT_CTL && wdata[CTL_STOP_BIT]) |=> st_q == ST_IDLE);
  a_r11_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (we && tgt == TGT_NONE) |=> $stable({data_q, ctl_q, clk_q, thp_q, st_q}));
endmodule

// File: rtl/twsi_cmd_bridge.sv
module twsi_cmd_bridge
  import twsi_br_pkg::*;
#(
  parameter int LATENCY = 2,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  output logic              irq,
  output logic              scl_force,
  output logic              sda_force,
  output logic [7:0]        clk_div_cfg,
  output logic [7:0]        clk_hi_period
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [ADDR_W-1:0] CMD_OFF = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] AUX_OFF = ADDR_W'(8'h10);

  logic [WORD_W-1:0] cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              irq_en_q, scl_q, sda_q;
  logic              busy, fire, accept, reg_we;
  twsi_tgt_e         tgt;
  logic [7:0]        rd_byte, status;

  assign busy   = cmd_q[VALID_BIT];
  assign fire   = busy && (cnt_q == CNT_W'(LATENCY - 1));
  assign accept = csr_wr && (csr_addr == CMD_OFF) && !busy;
  assign reg_we = fire && !cmd_q[RD_BIT];

  twsi_cmd_decode u_dec (
    .op  (cmd_q[OP_HI:OP_LO]),
    .sel (cmd_q[SEL_HI:SEL_LO]),
    .tgt (tgt)
  );

  twsi_reg_model u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .tgt       (tgt),
    .wdata     (cmd_q[7:0]),
    .rdata     (rd_byte),
    .status    (status),
    .clk_cfg   (clk_div_cfg),
    .hi_period (clk_hi_period)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      cmd_q <= csr_wdata;
      cnt_q <= '0;
    end else if (fire) begin
      cmd_q[VALID_BIT] <= 1'b0;
      if (cmd_q[RD_BIT]) cmd_q[7:0] <= rd_byte;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
    end else if (csr_wr && csr_addr == AUX_OFF) begin
      irq_en_q <= csr_wdata[AUX_IRQ_BIT];
      scl_q    <= csr_wdata[AUX_SCL_BIT];
      sda_q    <= csr_wdata[AUX_SDA_BIT];
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == CMD_OFF) begin
      csr_rdata = cmd_q;
    end else if (csr_addr == AUX_OFF) begin
      csr_rdata[AUX_IRQ_BIT] = irq_en_q;
      csr_rdata[AUX_SCL_BIT] = scl_q;
      csr_rdata[AUX_SDA_BIT] = sda_q;
    end
  end

  assign irq       = irq_en_q && (status != ST_IDLE);
  assign scl_force = scl_q;
  assign sda_force = sda_q;

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> $stable(cmd_q));
  a_r2_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !cmd_q[VALID_BIT]);
  a_r3_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_q[RD_BIT]) |=> cmd_q[7:0] == $past(rd_byte));
  a_r3_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cmd_q[RD_BIT]) |=> $stable(cmd_q[7:0]));

  generate
    if (LATENCY >= 2) begin : g_hold
      a_r2_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    end
  endgenerate
endmodule

// File: tb/twsi_cmd_bridge_tb.sv
`timescale 1ns/1ps
module twsi_cmd_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [4:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        irq, scl_force, sda_force;
  logic [7:0]  clk_div_cfg, clk_hi_period;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  twsi_cmd_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
    .scl_force(scl_force), .sda_force(sda_force),
    .clk_div_cfg(clk_div_cfg), .clk_hi_period(clk_hi_period)
  );

  function automatic logic [63:0] mk(input logic [1:0] op, input logic rd,
                                     input logic [2:0] sel, input logic [7:0] dat);
    mk = {1'b1, 3'b0, op, 1'b0, rd, 21'b0, sel, 24'b0, dat};
  endfunction

  // {command, expected low byte after completion, requirement number}
  localparam int NV = 25;
  localparam logic [79:0] VEC [NV] = '{
    {mk(2'b11,1'b0,3'd1,8'h5A), 8'h5A, 8'd4},  // R4 data write
    {mk(2'b11,1'b1,3'd1,8'h00), 8'h5A, 8'd3},  // R3 data read
    {mk(2'b11,1'b0,3'd2,8'h40), 8'h40, 8'd4},  // R4 control write
    {mk(2'b11,1'b1,3'd2,8'h00), 8'h40, 8'd4},  // R4 control read
    {mk(2'b11,1'b1,3'd3,8'h00), 8'hF8, 8'd4},  // R4 status read idle
    {mk(2'b11,1'b0,3'd2,8'h60), 8'h60, 8'd7},  // R7 start
    {mk(2'b11,1'b1,3'd3,8'h00), 8'h08, 8'd7},
    {mk(2'b11,1'b0,3'd2,8'h50), 8'h50, 8'd7},  // R7 stop
    {mk(2'b11,1'b1,3'd3,8'h00), 8'hF8, 8'd7},
    {mk(2'b11,1'b0,3'd2,8'h60), 8'h60, 8'd7},
    {mk(2'b11,1'b0,3'd2,8'h30), 8'h30, 8'd7},  // R7 both set: stop wins
    {mk(2'b11,1'b1,3'd3,8'h00), 8'hF8, 8'd7},
    {mk(2'b10,1'b0,3'd0,8'h1C), 8'h1C, 8'd5},  // R5 high period
    {mk(2'b10,1'b1,3'd0,8'h00), 8'h1C, 8'd5},
    {mk(2'b11,1'b0,3'd3,8'h13), 8'h13, 8'd4},  // R4 clock-control write
    {mk(2'b10,1'b1,3'd1,8'hAA), 8'h00, 8'd11}, // R11 unmapped read
    {mk(2'b01,1'b1,3'd1,8'h77), 8'h00, 8'd11},
    {mk(2'b11,1'b0,3'd2,8'h60), 8'h60, 8'd6},
    {mk(2'b11,1'b0,3'd7,8'h00), 8'h00, 8'd6},  // R6 soft reset
    {mk(2'b11,1'b1,3'd3,8'h00), 8'hF8, 8'd6},
    {mk(2'b11,1'b1,3'd2,8'h00), 8'h00, 8'd6},
    {mk(2'b11,1'b1,3'd1,8'h00), 8'h00, 8'd6},
    {mk(2'b01,1'b0,3'd1,8'hEE), 8'hEE, 8'd11}, // R11 unmapped write
    {mk(2'b11,1'b1,3'd1,8'h00), 8'h00, 8'd11},
    {mk(2'b10,1'b1,3'd0,8'h00), 8'h1C, 8'd6}   // R6 high period kept
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic wait_idle(output logic [63:0] w);
    csr_addr = 5'h00;
    for (int i = 0; i < 20; i++) begin
      if (!csr_rdata[63]) break;
      @(negedge clk);
    end
    w = csr_rdata;
  endtask

  task automatic run_cmd(input logic [63:0] c, output logic [63:0] w);
    host_wr(5'h00, c);
    wait_idle(w);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] w;
    repeat (3) @(negedge clk);
    // R1 reset state
    csr_addr = 5'h00; #1; chk("R1", csr_rdata, 64'h0);
    csr_addr = 5'h10; #1; chk("R1", csr_rdata, 64'h0);
    chk("R1", {61'b0, irq, scl_force, sda_force}, 64'h0);
    rst_n = 1'b1;

    // R2 exact completion timing
    host_wr(5'h00, mk(2'b11, 1'b0, 3'd1, 8'h3C));
    csr_addr = 5'h00; #1;
    chk("R2", {63'b0, csr_rdata[63]}, 64'd1);
    @(negedge clk);
    chk("R2", {63'b0, csr_rdata[63]}, 64'd1);
    @(negedge clk);
    chk("R2", csr_rdata, mk(2'b11, 1'b0, 3'd1, 8'h3C) & ~(64'd1 << 63));

    // table walk: R2 word preserved, R3 low byte
    for (int i = 0; i < NV; i++) begin
      logic [63:0] c;
      c = VEC[i][79:16];
      run_cmd(c, w);
      total++;
      if (w !== {1'b0, c[62:8], VEC[i][15:8]}) begin
        bad++;
        $display("FAIL R%0d vec %0d: actual=%h expected=%h", VEC[i][7:0], i, w,
                 {1'b0, c[62:8], VEC[i][15:8]});
      end
    end
    chk("R4", {56'b0, clk_div_cfg}, 64'h13);
    chk("R5", {56'b0, clk_hi_period}, 64'h1C);

    // R8 second command during busy window is dropped
    host_wr(5'h00, mk(2'b11, 1'b0, 3'd1, 8'h11));
    host_wr(5'h00, mk(2'b11, 1'b0, 3'd1, 8'h22));
    wait_idle(w);
    chk("R8", {56'b0, w[7:0]}, 64'h11);
    run_cmd(mk(2'b11, 1'b1, 3'd1, 8'h00), w);
    chk("R8", {56'b0, w[7:0]}, 64'h11);

    // R9 control word
    host_wr(5'h10, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_addr = 5'h10; #1;
    chk("R9", csr_rdata, 64'h340);
    chk("R9", {62'b0, scl_force, sda_force}, 64'd3);
    host_wr(5'h10, 64'h200);
    csr_addr = 5'h10; #1;
    chk("R9", {62'b0, scl_force, sda_force}, 64'd2);

    // R10 interrupt
    host_wr(5'h10, 64'h40);
    chk("R10", {63'b0, irq}, 64'd0);
    run_cmd(mk(2'b11, 1'b0, 3'd2, 8'h60), w);
    @(negedge clk);
    chk("R10", {63'b0, irq}, 64'd1);
    host_wr(5'h10, 64'h0);
    chk("R10", {63'b0, irq}, 64'd0);
    host_wr(5'h10, 64'h40);
    run_cmd(mk(2'b11, 1'b0, 3'd2, 8'h50), w);
    @(negedge clk);
    chk("R10", {63'b0, irq}, 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule